// File: doc/BRIEF.md
# Fractional Baud Clock Prescaler

This block divides the system clock by a programmable ratio of the form M + N/8 and produces a train of single-cycle enable pulses. The average pulse rate is the clock rate divided by that ratio. The integer part M is a 5-bit value. The eighths part N is a 3-bit value. Together they cover 1 to 31.875 in steps of one eighth. The pulse train drives the enable of a downstream baud-rate divisor, which is outside this block.

Each pulse period lasts either M or M+1 clock cycles. A 3-bit phase accumulator chooses the longer periods, and N of every eight periods are long. It spreads them evenly, so the rate error never builds up. The ratio may be rewritten at any time. A new ratio is taken up only when a new period begins, so the period already in progress keeps its length.

Top module: `frac_prescaler`

## Requirements
- R1: While `rst_n` is low, `tick` is low. Reset clears the cycle count and sets the phase accumulator to 0.
- R2: Every period ends with one cycle of `tick` high. A period lasts M or M+1 cycles, where M and N are the values of `div_int` and `div_frac` in the first cycle of that period.
- R3: A value of 0 on `div_int` behaves exactly like a value of 1.
- R4: When N is 0, every period is exactly M cycles long.
- R5: The accumulator P starts at 0. A period that starts with ratio N is M+1 cycles long exactly when P + N >= 8. After that, P becomes (P + N) mod 8. Across eight consecutive periods with a constant N, exactly N periods are long.
- R6: With a ratio of exactly 1.0 (`div_int` 0 or 1, `div_frac` 0), `tick` is high on every clock cycle.
- R7: A ratio change made partway through a period does not alter that period's length. The change applies from the next period on, and the accumulator value carries over.
- R8: After reset is released, the first period is M cycles long, so the first `tick` comes in the M-th cycle.
- R9: At the largest ratio, 31.875, periods of 31 and 32 cycles occur, and no period is longer than 32 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_int | input | 5 | Integer part M of the ratio |
| div_frac | input | 3 | Eighths part N of the ratio |
| tick | output | 1 | Single-cycle enable pulse at the end of each period |

## Verification
The bench builds the block with its default widths: a 5-bit integer part and a 3-bit fraction. These widths give the full range from 1.0 to 31.875. The following are therefore reachable:
- the every-cycle case;
- the 32-cycle longest period;
- the remap of M = 0;
- all eight accumulator phases.

A period-level model follows the accumulator rule. Random ratio rewrites land at arbitrary points inside periods, and each of these tests that a period in progress keeps its length.

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
  parameter int INT_W  = 5,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  localparam int CW = INT_W + 1;

  logic [CW-1:0]     cnt, len_q, m_eff, start_len, cur_len;
  logic [FRAC_W-1:0] phase;
  logic [FRAC_W:0]   sum;
  logic              at_start;

  assign at_start  = (cnt == '0);
  assign m_eff     = (div_int == '0) ? CW'(1) : CW'(div_int);
  assign sum       = {1'b0, phase} + {1'b0, div_frac};
  assign start_len = m_eff + CW'(sum[FRAC_W]);
  assign cur_len   = at_start ? start_len : len_q;
  assign tick      = rst_n && (cnt == cur_len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      len_q <= CW'(1);
      phase <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (at_start) begin
        len_q <= start_len;
        phase <= sum[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/frac_prescaler_chk.sv
module frac_prescaler_chk #(
  parameter int INT_W  = 5,
  parameter int FRAC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [INT_W-1:0]  div_int,
  input logic [FRAC_W-1:0] div_frac,
  input logic              tick
);
  localparam int EW     = INT_W + 2;
  localparam int MAXLEN = 2 ** INT_W;

  logic [EW-1:0]     el, len_now, mval, m_q;
  logic [FRAC_W-1:0] fval, f_q;

  assign len_now = el + EW'(1);
  assign mval = (el == '0) ? ((div_int == '0) ? EW'(1) : EW'(div_int)) : m_q;
  assign fval = (el == '0) ? div_frac : f_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el  <= '0;
      m_q <= EW'(1);
      f_q <= '0;
    end else begin
      el  <= tick ? '0 : el + EW'(1);
      m_q <= mval;
      f_q <= fval;
    end
  end

  always_comb begin
    if (!rst_n) a_r1_quiet_in_reset: assert (!tick);
  end

  a_r2_len_window: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (len_now >= mval && len_now <= mval + EW'(1)));

  a_r4_whole_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fval == '0) |-> (len_now == mval));

  a_r6_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (el == '0 && mval == EW'(1) && fval == '0) |-> tick);

  a_r9_max_period: assert property (@(posedge clk) disable iff (!rst_n)
    el < EW'(MAXLEN));
endmodule

bind frac_prescaler frac_prescaler_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk (.*);

// File: tb/frac_prescaler_test.sv
`timescale 1ns/1ps
module frac_prescaler_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] div_int = 5'd3;
  logic [2:0] div_frac = 3'd0;
  logic       tick;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  bit st = 1'b1;
  int phase = 0;
  int el = 0;
  int exp_len = 0;

  always #5 clk = ~clk;

  frac_prescaler uut (.clk(clk), .rst_n(rst_n), .div_int(div_int),
                      .div_frac(div_frac), .tick(tick));

  function automatic int m_of(int m);
    return (m == 0) ? 1 : m;
  endfunction

  task automatic monitor();
    if (st) begin
      exp_len = m_of(int'(div_int)) + (((phase + int'(div_frac)) >= 8) ? 1 : 0);
      phase   = (phase + int'(div_frac)) % 8;
      el = 0;
      st = 1'b0;
    end
    el++;
    if (tick || el >= exp_len) begin
      checks++;
      if (!(tick && el == exp_len)) begin
        fails++;
        $display("FAIL %s: period length actual %0d (tick=%0d) expected %0d",
                 tag, el, tick, exp_len);
      end
      st = 1'b1;
    end
  endtask

  task automatic step(input int m, input int f);
    @(posedge clk); #1;
    div_int = 5'(m); div_frac = 3'(f);
    @(negedge clk); #1;
    monitor();
  endtask

  task automatic run(input int n, input int m, input int f);
    for (int i = 0; i < n; i++) step(m, f);
  endtask

  task automatic do_reset(input int m, input int f);
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1; div_int = 5'(m); div_frac = 3'(f);
    st = 1'b1; phase = 0;
    @(negedge clk); #1;
    monitor();
  endtask

  task automatic check_low(input string t);
    checks++;
    if (tick !== 1'b0) begin
      fails++;
      $display("FAIL %s: tick in reset actual %0d expected 0", t, tick);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: quiet while reset held, even for a 1.0 ratio
    @(negedge clk); #1; check_low("R1");
    div_int = 5'd1; div_frac = 3'd0;
    @(negedge clk); #1; check_low("R1");

    // R8: first period is M after release
    tag = "R8";
    do_reset(5, 3);
    run(4, 5, 3);
    // R5: spreading of long periods, fresh phase
    tag = "R5";
    do_reset(2, 3);
    run(60, 2, 3);
    // R3: zero integer part
    tag = "R3";
    run(10, 0, 0);
    run(30, 0, 5);
    // R6: ratio 1.0
    tag = "R6";
    run(20, 1, 0);
    run(20, 0, 0);
    // R4: whole ratio
    tag = "R4";
    run(60, 7, 0);
    // R9: maximum ratio
    tag = "R9";
    run(400, 31, 7);
    // R7: change partway through a long period
    tag = "R7";
    do_reset(20, 0);
    run(9, 20, 0);
    run(40, 2, 5);
    run(3, 30, 1);
    run(60, 1, 4);
    // R2: random rewrites at arbitrary points
    tag = "R2";
    begin
      int m = 9;
      int f = 2;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(39) == 0) begin
          m = int'($urandom_range(31));
          f = int'($urandom_range(7));
        end
        step(m, f);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule